// File: doc/BRIEF.md
# Fault Latch and Standby Supervisor

This block sits between the protection detectors of a stepper power stage and the gate drivers. It qualifies the thermal and over-current detector flags, latches a confirmed fault, and from the latched state and the resolution code it produces four registered results. These are an active-low error flag, an enable for the chopping oscillator, an enable for the H-bridges that forces every gate off when low, and a standby indication for the step sequencer.

A latched fault survives the removal of its cause and the toggling of the enable pin. Only two things clear it: a power-on reset, or selecting the all-zero resolution code that means standby. A thermal fault also places the block in standby by itself. An over-current fault only removes the bridge drive.

The block also cleans the step clock input. The input is synchronised, and it changes level only after it has held the new level for a minimum number of system-clock samples. The minimum for a high level and the minimum for a low level are set apart. Each accepted rising level gives a one-cycle pulse to the sequencer.

Top module: `fault_supervisor`

## Requirements
- R1: While `por_i` is high, the outputs are forced at once to `err_n_o`=1, `standby_o`=1, `osc_en_o`=0 and `bridge_en_o`=0. After `por_i` falls, reset stays in force for RST_STAGES clock edges. The outputs first follow their inputs at the edge after that.
- R2: A thermal flag latches only after it is sampled high on TSD_QUAL consecutive clock edges. A run of TSD_QUAL-1 samples leaves no trace.
- R3: An over-current flag latches only after it is sampled high on ISD_QUAL consecutive clock edges. A shorter run leaves no trace.
- R4: `err_n_o` goes low one edge after either fault latches. It stays low while a fault remains latched, and it returns high one edge after the last latch clears.
- R5: A latched fault persists after its flag drops, and toggling `enable_i` does not clear it.
- R6: A latched fault is cleared by `por_i`, or by driving `mode_i` to the standby code 3'b000. While the standby code is applied, a held flag does not latch.
- R7: A latched thermal fault forces `standby_o`=1, `osc_en_o`=0 and `bridge_en_o`=0. A latched over-current fault forces only `bridge_en_o`=0 and leaves `standby_o`=0 and `osc_en_o`=1.
- R8: `mode_i`=3'b000 gives `standby_o`=1, `osc_en_o`=0 and `bridge_en_o`=0 at the next edge. Each of the other seven codes gives `standby_o`=0 and `osc_en_o`=1 when no thermal fault is latched.
- R9: `bridge_en_o` is 0 one edge after `enable_i` is low. With `enable_i` high, no fault latched and a non-standby code, it is 1 one edge later.
- R10: A high level on `step_i` is accepted only after STEP_HI_MIN consecutive synchronised samples. The one-cycle `step_rise_o` pulse comes STEP_HI_MIN+1 edges after the first edge that sees `step_i` high. A high run one sample shorter gives no pulse.
- R11: A low gap shorter than STEP_LO_MIN samples between two high levels is ignored and gives no second pulse. A gap of at least STEP_LO_MIN samples re-arms the filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous assertion |
| tsd_flag_i | input | 1 | Raw thermal detector flag |
| isd_flag_i | input | 1 | Raw over-current detector flag |
| mode_i | input | 3 | Step resolution code; 3'b000 selects standby |
| enable_i | input | 1 | Output stage enable pin |
| step_i | input | 1 | Raw step clock input |
| err_n_o | output | 1 | Error flag, low while a fault is latched |
| osc_en_o | output | 1 | Chopping oscillator enable |
| bridge_en_o | output | 1 | Bridge enable; low forces every gate drive off |
| standby_o | output | 1 | Standby indication to the sequencer |
| step_rise_o | output | 1 | One-cycle pulse per accepted rising step level |

## Verification
The mode, enable and standby results are due one edge after their input is applied. A fault latches on the edge that takes the last qualifying sample, and the error flag follows one edge later. A step rise shows STEP_HI_MIN+1 edges after the first high sample, because of the two synchroniser flops. The bench drives every input on the falling clock edge. It advances exactly the number of rising edges these latencies call for, and it reads each output on the next falling edge. It also probes the cycle just before each result is due, so that a result arriving early or late is caught.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  localparam int FAULT_NUM = 2;
  localparam int FLT_THERM = 0;
  localparam int FLT_OVCUR = 1;
  localparam logic [2:0] MODE_STANDBY = 3'b000;
endpackage

// File: rtl/fsup_rst_sync.sv
module fsup_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_i,
  output logic rst_o
);
  logic [STAGES-1:0] chain;

  // asserts immediately, releases after STAGES clock edges
  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) chain <= '1;
    else       chain <= {chain[STAGES-2:0], 1'b0};
  end

  assign rst_o = chain[STAGES-1];
endmodule

// File: rtl/fsup_fault_qual.sv
module fsup_fault_qual #(
  parameter int QUAL = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic flag_i,
  output logic lat_o
);
  localparam int CW = $clog2(QUAL + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL - 1);

  logic [CW-1:0] run;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      run   <= '0;
      lat_o <= 1'b0;
    end else if (clr) begin
      run   <= '0;
      lat_o <= 1'b0;
    end else if (lat_o) begin
      run   <= '0;
    end else if (flag_i) begin
      if (run == LAST) begin
        lat_o <= 1'b1;
        run   <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end else begin
      run <= '0;
    end
  end
endmodule

// File: rtl/fsup_step_filter.sv
module fsup_step_filter #(
  parameter int HI_MIN = 75,
  parameter int LO_MIN = 63
) (
  input  logic clk,
  input  logic rst,
  input  logic step_i,
  output logic rise_o
);
  localparam int TMAX = (HI_MIN > LO_MIN) ? HI_MIN : LO_MIN;
  localparam int CW   = $clog2(TMAX + 1);

  logic [1:0]    sync;
  logic          lvl;
  logic [CW-1:0] run;
  logic [CW-1:0] lim;

  // the limit depends on the level being left
  assign lim = lvl ? CW'(LO_MIN - 1) : CW'(HI_MIN - 1);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sync   <= '0;
      lvl    <= 1'b0;
      run    <= '0;
      rise_o <= 1'b0;
    end else begin
      sync   <= {sync[0], step_i};
      rise_o <= 1'b0;
      if (sync[1] == lvl) begin
        run <= '0;
      end else if (run == lim) begin
        lvl    <= sync[1];
        run    <= '0;
        rise_o <= sync[1];
      end else begin
        run <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int TSD_QUAL    = 16,
  parameter int ISD_QUAL    = 8,
  parameter int STEP_HI_MIN = 75,
  parameter int STEP_LO_MIN = 63,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       por_i,
  input  logic       tsd_flag_i,
  input  logic       isd_flag_i,
  input  logic [2:0] mode_i,
  input  logic       enable_i,
  input  logic       step_i,
  output logic       err_n_o,
  output logic       osc_en_o,
  output logic       bridge_en_o,
  output logic       standby_o,
  output logic       step_rise_o
);
  logic                 rst_int;
  logic                 standby_code;
  logic                 sleep;
  logic [FAULT_NUM-1:0] flag_raw;
  logic [FAULT_NUM-1:0] fault_lat;

  fsup_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk   (clk),
    .por_i (por_i),
    .rst_o (rst_int)
  );

  assign standby_code        = (mode_i == MODE_STANDBY);
  assign flag_raw[FLT_THERM] = tsd_flag_i;
  assign flag_raw[FLT_OVCUR] = isd_flag_i;

  for (genvar g = 0; g < FAULT_NUM; g++) begin : g_qual
    localparam int QUAL = (g == FLT_THERM) ? TSD_QUAL : ISD_QUAL;
    fsup_fault_qual #(.QUAL(QUAL)) i_qual (
      .clk    (clk),
      .rst    (rst_int),
      .clr    (standby_code),
      .flag_i (flag_raw[g]),
      .lat_o  (fault_lat[g])
    );
  end

  // a thermal fault puts the block to sleep like the standby code does
  assign sleep = standby_code | fault_lat[FLT_THERM];

  always_ff @(posedge clk or posedge rst_int) begin
    if (rst_int) begin
      err_n_o     <= 1'b1;
      osc_en_o    <= 1'b0;
      bridge_en_o <= 1'b0;
      standby_o   <= 1'b1;
    end else begin
      err_n_o     <= ~|fault_lat;
      osc_en_o    <= ~sleep;
      bridge_en_o <= enable_i & ~sleep & ~|fault_lat;
      standby_o   <= sleep;
    end
  end

  fsup_step_filter #(.HI_MIN(STEP_HI_MIN), .LO_MIN(STEP_LO_MIN)) i_step (
    .clk    (clk),
    .rst    (rst_int),
    .step_i (step_i),
    .rise_o (step_rise_o)
  );
endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk (
  input logic       clk,
  input logic       por_i,
  input logic       rst_int,
  input logic [2:0] mode_i,
  input logic       enable_i,
  input logic [1:0] fault_lat,
  input logic       err_n_o,
  input logic       osc_en_o,
  input logic       bridge_en_o,
  input logic       standby_o,
  input logic       step_rise_o
);
  AST_POR_SAFE: assert property (@(posedge clk)
    por_i |-> (standby_o && err_n_o && !osc_en_o && !bridge_en_o)); // R1

  AST_ERR_FOLLOWS: assert property (@(posedge clk) disable iff (rst_int)
    (|fault_lat) |=> !err_n_o); // R4

  AST_OVCUR_HOLDS: assert property (@(posedge clk) disable iff (rst_int)
    (fault_lat[1] && mode_i != 3'b000) |=> fault_lat[1]); // R5

  AST_THERM_SLEEP: assert property (@(posedge clk) disable iff (rst_int)
    fault_lat[0] |=> (standby_o && !osc_en_o && !bridge_en_o)); // R7

  AST_STANDBY_CODE: assert property (@(posedge clk) disable iff (rst_int)
    (mode_i == 3'b000) |=> (standby_o && !osc_en_o && !bridge_en_o)); // R8

  AST_ENABLE_LOW: assert property (@(posedge clk) disable iff (rst_int)
    !enable_i |=> !bridge_en_o); // R9

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst_int)
    step_rise_o |=> !step_rise_o); // R10
endmodule

bind fault_supervisor fault_supervisor_chk i_chk (
  .clk         (clk),
  .por_i       (por_i),
  .rst_int     (rst_int),
  .mode_i      (mode_i),
  .enable_i    (enable_i),
  .fault_lat   (fault_lat),
  .err_n_o     (err_n_o),
  .osc_en_o    (osc_en_o),
  .bridge_en_o (bridge_en_o),
  .standby_o   (standby_o),
  .step_rise_o (step_rise_o)
);

// File: tb/test_fault_supervisor.sv
module test_fault_supervisor;
  localparam int TQ = 16;
  localparam int IQ = 8;
  localparam int HI = 75;
  localparam int LO = 63;

  logic       clk = 1'b0;
  logic       por_i, tsd_flag_i, isd_flag_i, enable_i, step_i;
  logic [2:0] mode_i;
  logic       err_n_o, osc_en_o, bridge_en_o, standby_o, step_rise_o;

  int n_chk = 0;
  int n_err = 0;
  int rises = 0;
  bit done  = 0;

  always #2 clk = ~clk; // 4 ns period

  fault_supervisor #(
    .TSD_QUAL(TQ), .ISD_QUAL(IQ), .STEP_HI_MIN(HI), .STEP_LO_MIN(LO), .RST_STAGES(2)
  ) i_fault_supervisor (
    .clk, .por_i, .tsd_flag_i, .isd_flag_i, .mode_i, .enable_i, .step_i,
    .err_n_o, .osc_en_o, .bridge_en_o, .standby_o, .step_rise_o
  );

  always @(negedge clk) if (step_rise_o === 1'b1) rises++;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int e_err, input int e_sb,
                         input int e_osc, input int e_br);
    chk({req, " err_n"},  int'(err_n_o),     e_err);
    chk({req, " standby"}, int'(standby_o),  e_sb);
    chk({req, " osc_en"},  int'(osc_en_o),   e_osc);
    chk({req, " bridge"},  int'(bridge_en_o), e_br);
  endtask

  task automatic t_reset;
    chk_out("R1 during por", 1, 1, 0, 0);
    por_i = 1'b0;
    cyc(2);
    chk_out("R1 release pending", 1, 1, 0, 0);
    cyc(1);
    chk_out("R1 released", 1, 0, 1, 0);
  endtask

  task automatic t_enable;
    enable_i = 1'b1; cyc(1);
    chk("R9 enable high", int'(bridge_en_o), 1);
    enable_i = 1'b0; cyc(1);
    chk("R9 enable low", int'(bridge_en_o), 0);
    enable_i = 1'b1; cyc(1);
    chk("R9 enable back", int'(bridge_en_o), 1);
  endtask

  task automatic t_modes;
    for (int c = 0; c < 8; c++) begin
      mode_i = 3'(c);
      cyc(1);
      chk_out($sformatf("R8 code %0d", c), 1, (c == 0) ? 1 : 0,
              (c == 0) ? 0 : 1, (c == 0) ? 0 : 1);
    end
    mode_i = 3'b001; cyc(1);
  endtask

  task automatic t_thermal;
    tsd_flag_i = 1'b1; cyc(TQ - 1);
    tsd_flag_i = 1'b0; cyc(3);
    chk_out("R2 short thermal", 1, 0, 1, 1);
    tsd_flag_i = 1'b1; cyc(TQ);
    tsd_flag_i = 1'b0;
    chk("R4 err not yet", int'(err_n_o), 1);
    cyc(1);
    chk_out("R2 R4 R7 thermal latched", 0, 1, 0, 0);
    enable_i = 1'b0; cyc(2);
    enable_i = 1'b1; cyc(3);
    chk_out("R5 thermal persists", 0, 1, 0, 0);
    mode_i = 3'b000; cyc(1);
    chk("R4 err one edge late", int'(err_n_o), 0);
    cyc(1);
    chk("R6 standby clears", int'(err_n_o), 1);
    mode_i = 3'b001; cyc(2);
    chk_out("R6 resumed", 1, 0, 1, 1);
  endtask

  task automatic t_overcurrent;
    isd_flag_i = 1'b1; cyc(IQ - 1);
    isd_flag_i = 1'b0; cyc(3);
    chk("R3 short overcurrent", int'(err_n_o), 1);
    isd_flag_i = 1'b1; cyc(IQ + 1);
    isd_flag_i = 1'b0;
    chk_out("R3 R7 overcurrent latched", 0, 0, 1, 0);
    enable_i = 1'b0; cyc(2);
    enable_i = 1'b1; cyc(3);
    chk("R5 overcurrent persists", int'(err_n_o), 0);
    por_i = 1'b1; cyc(1);
    chk_out("R1 R6 por clears", 1, 1, 0, 0);
    por_i = 1'b0; cyc(3);
    chk_out("R6 after por", 1, 0, 1, 1);
    mode_i = 3'b000; isd_flag_i = 1'b1; cyc(2 * IQ);
    mode_i = 3'b001; isd_flag_i = 1'b0; cyc(2);
    chk("R6 no latch in standby", int'(err_n_o), 1);
  endtask

  task automatic t_step;
    int base;
    base = rises;
    step_i = 1'b1; cyc(HI - 1);
    step_i = 1'b0; cyc(100);
    chk("R10 short high rejected", rises - base, 0);
    step_i = 1'b1; cyc(HI);
    step_i = 1'b0; cyc(1);
    chk("R10 pulse not yet", int'(step_rise_o), 0);
    cyc(1);
    chk("R10 pulse due", int'(step_rise_o), 1);
    cyc(100);
    chk("R10 one rise", rises - base, 1);
    step_i = 1'b1; cyc(HI + 10);
    step_i = 1'b0; cyc(LO - 1);
    step_i = 1'b1; cyc(HI + 10);
    chk("R11 short low ignored", rises - base, 2);
    step_i = 1'b0; cyc(LO + 5);
    step_i = 1'b1; cyc(HI + 10);
    step_i = 1'b0; cyc(100);
    chk("R11 long low rearms", rises - base, 3);
  endtask

  initial begin
    por_i = 1'b1; tsd_flag_i = 1'b0; isd_flag_i = 1'b0;
    mode_i = 3'b001; enable_i = 1'b0; step_i = 1'b0;
    cyc(3);
    t_reset;
    t_enable;
    t_modes;
    t_thermal;
    t_overcurrent;
    t_step;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule